// File: doc/BRIEF.md
# Scan-Decimating Sample Formatter

This streaming stage sits between the read side of an ADC sample FIFO and a consumer, with a valid/ready handshake on both sides. It does two things to each raw 16-bit word it takes in. First, it turns the word into a signed-offset sample. In full-resolution mode this flips the top bit. In 12-bit mode it moves the field in bits 15:4 down to bit 0 and flips bit 11. Second, it decides whether the sample goes on at all.

The decision uses a running position inside a repeating chunk of `scan_len × (1 + skip_scans)` samples. Positions below `scan_len` form one whole scan and are forwarded. The remaining positions are the skipped scans, and they are consumed and discarded. This lets a single fast conversion pacer stand in for a slower scan rate. Software picks `skip_scans` as the scan period divided by `scan_len` times the conversion period, minus one.

The position survives idle gaps on the input, so bursts of any length can split a chunk anywhere. A `clear` pulse restarts the position at the start of a chunk.

Top module: `scan_decimator`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, and the first accepted sample is treated as chunk position 0.
- R2: With `hi_res`=1 a forwarded sample equals the raw word XOR 16'h8000.
- R3: With `hi_res`=0 a forwarded sample equals {4'h0, raw[15:4]} XOR 16'h0800.
- R4: Accepted samples at positions 0 to `scan_len`-1 are forwarded in order. Samples at positions `scan_len` to chunk length minus 1 produce no output.
- R5: The position returns to 0 after the sample at position chunk length minus 1, and the keep/drop pattern then repeats.
- R6: With `skip_scans`=0 every accepted sample is forwarded.
- R7: Cycles with `in_valid` low do not move the position, so a chunk may be split across bursts at any point.
- R8: While `out_valid`=1 and `out_ready`=0, `out_valid` stays 1 and `out_data` stays stable. A sample whose position would be kept is not accepted (`in_ready`=0), and no position is lost.
- R9: A sample at a dropped position is accepted in one cycle (`in_ready`=1) even while the output is stalled.
- R10: While `clear` is 1, `in_ready` is 0 and no input is consumed. The next accepted sample is at position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Restart the chunk position at 0 |
| hi_res | input | 1 | 1: 16-bit conversion, 0: 12-bit conversion |
| scan_len | input | SCAN_W | Samples per scan (N), at least 1 |
| skip_scans | input | SKIP_W | Whole scans dropped after each kept scan (D) |
| in_valid | input | 1 | Raw sample present |
| in_data | input | 16 | Raw ADC word |
| in_ready | output | 1 | Raw sample accepted this cycle when valid |
| out_valid | output | 1 | Converted sample present |
| out_data | output | 16 | Converted sample |
| out_ready | input | 1 | Consumer takes the sample this cycle |

## Verification
Two things can fall in the same cycle: a `clear` pulse and an input handshake. The bench provokes this by raising `clear` while `in_valid` is already high with a pending word. It checks that `in_ready` is low in that cycle. It then checks that the following word is forwarded as position 0, where it would have been dropped without the clear. Output back-pressure is also exercised alongside dropped positions, to show that drops still flow while a kept sample is held.

// File: rtl/scan_decimator.sv
module scan_decimator #(
  parameter int SCAN_W = 5,
  parameter int SKIP_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              hi_res,
  input  logic [SCAN_W-1:0] scan_len,
  input  logic [SKIP_W-1:0] skip_scans,
  input  logic              in_valid,
  input  logic [15:0]       in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [15:0]       out_data,
  input  logic              out_ready
);
  localparam int POS_W = SCAN_W + SKIP_W + 1;

  logic [POS_W-1:0] pos, pos_inc, chunk_len;
  logic             keep, out_free, take;
  logic [15:0]      conv;

  assign chunk_len = POS_W'(scan_len) * (POS_W'(skip_scans) + POS_W'(1));
  assign pos_inc   = pos + POS_W'(1);
  assign keep      = pos < POS_W'(scan_len);
  assign out_free  = !out_valid || out_ready;
  assign in_ready  = !clear && (!keep || out_free);
  assign take      = in_valid && in_ready;
  assign conv      = hi_res ? (in_data ^ 16'h8000)
                            : ({4'h0, in_data[15:4]} ^ 16'h0800);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0;
    end else if (clear) begin
      pos <= '0;
    end else if (take) begin
      pos <= (pos_inc >= chunk_len) ? '0 : pos_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (out_free) begin
      out_valid <= take && keep;
      if (take && keep) out_data <= conv;
    end
  end
endmodule

module scan_decimator_chk #(
  parameter int SCAN_W = 5,
  parameter int SKIP_W = 6,
  localparam int POS_W = SCAN_W + SKIP_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clear,
  input logic              hi_res,
  input logic [SCAN_W-1:0] scan_len,
  input logic [SKIP_W-1:0] skip_scans,
  input logic              in_valid,
  input logic [15:0]       in_data,
  input logic              in_ready,
  input logic              out_valid,
  input logic [15:0]       out_data,
  input logic              out_ready,
  input logic [POS_W-1:0]  pos,
  input logic [POS_W-1:0]  chunk_len
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R8

  AST_CLEAR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    clear |-> !in_ready); // R10

  AST_CLEAR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> pos == '0); // R10

  AST_DROP_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !clear && pos >= POS_W'(scan_len) |-> in_ready); // R9

  AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && pos >= POS_W'(scan_len) && out_ready |=> !out_valid); // R4

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && POS_W'(pos + POS_W'(1)) == chunk_len |=> pos == '0); // R5

  AST_HI_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && hi_res && pos < POS_W'(scan_len)
    |=> out_valid && out_data == ($past(in_data) ^ 16'h8000)); // R2
endmodule

bind scan_decimator scan_decimator_chk #(.SCAN_W(SCAN_W), .SKIP_W(SKIP_W)) u_chk (.*);

// File: tb/tb_scan_decimator.sv
module tb_scan_decimator;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  localparam int V_HI[NV]    = '{1, 0, 1, 0, 1, 0};
  localparam int V_N[NV]     = '{3, 3, 4, 1, 5, 2};
  localparam int V_D[NV]     = '{2, 2, 0, 5, 1, 3};
  localparam int V_CNT[NV]   = '{40, 40, 21, 30, 47, 33};
  localparam int V_GAP[NV]   = '{0, 1, 0, 1, 1, 0};
  localparam int V_STALL[NV] = '{0, 1, 1, 0, 1, 1};

  logic clk = 0, rst_n = 0, clear = 0, hi_res = 1;
  logic [4:0] scan_len = 5'd1;
  logic [5:0] skip_scans = '0;
  logic in_valid = 0, out_ready = 1;
  logic [15:0] in_data = '0;
  logic in_ready, out_valid;
  logic [15:0] out_data;

  int checks = 0, errors = 0, rdy_mode = 0, exp_wr = 0, exp_rd = 0;
  bit mon_en = 0, finished = 0;
  logic [15:0] exp_q [0:255];
  logic [15:0] lfsr = 16'hACE1;

  scan_decimator dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] fmt(input logic hi, input logic [15:0] raw);
    return hi ? (raw ^ 16'h8000) : ((raw >> 4) ^ 16'h0800);
  endfunction

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? lfsr[0] : 1'b0;
  end

  always @(negedge clk) begin
    #1;
    if (mon_en && out_valid && out_ready) begin
      if (exp_rd >= exp_wr) check(0, "R4 extra output", out_data, 16'hxxxx);
      else begin
        check(out_data == exp_q[exp_rd], "R2 R3 R4 R5 R6 R7 R8 stream", out_data, exp_q[exp_rd]);
        exp_rd++;
      end
    end
  end

  task automatic send(input logic [15:0] raw);
    @(negedge clk);
    in_valid = 1; in_data = raw;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    #2;
  endtask

  task automatic pulse_clear();
    @(negedge clk); clear = 1;
    @(negedge clk); clear = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check(!out_valid && in_ready, "R1 reset state", {14'h0, out_valid, in_ready}, 16'h0001);

    for (int v = 0; v < NV; v++) begin
      int mpos, chunk;
      hi_res = V_HI[v][0]; scan_len = 5'(V_N[v]); skip_scans = 6'(V_D[v]);
      if (v > 0) pulse_clear();
      rdy_mode = V_STALL[v]; exp_wr = 0; exp_rd = 0; mon_en = 1;
      mpos = 0; chunk = V_N[v] * (1 + V_D[v]);
      for (int i = 0; i < V_CNT[v]; i++) begin
        logic [15:0] raw;
        raw = 16'(i * 16'h1357 + v * 16'h0F0F + 16'h0042);
        if (mpos < V_N[v]) begin exp_q[exp_wr] = fmt(V_HI[v][0], raw); exp_wr++; end
        mpos = (mpos + 1 == chunk) ? 0 : mpos + 1;
        send(raw);
        if (V_GAP[v] != 0 && i % 3 == 2) repeat (i % 4 + 1) @(negedge clk);
      end
      rdy_mode = 0;
      repeat (6) @(negedge clk);
      #3;
      check(exp_rd == exp_wr, "R4 R5 R6 forwarded count", 16'(exp_rd), 16'(exp_wr));
      mon_en = 0;
    end

    // clear in the same cycle as a pending input handshake
    hi_res = 1; scan_len = 5'd1; skip_scans = 6'd1; rdy_mode = 0;
    @(negedge clk);
    in_valid = 1; in_data = 16'h1111; clear = 1;
    #1;
    check(!in_ready, "R10 ready low during clear", {15'h0, in_ready}, 16'h0000);
    @(negedge clk); clear = 0; in_valid = 0;
    send(16'h1234);
    check(out_valid && out_data == 16'h9234, "R1 R10 position 0 kept", out_data, 16'h9234);
    send(16'h2222);
    check(!out_valid, "R4 dropped position silent", {15'h0, out_valid}, 16'h0000);
    send(16'h3333);
    check(out_valid && out_data == 16'hB333, "R5 wrap keeps next", out_data, 16'hB333);
    pulse_clear();
    send(16'h4444);
    check(out_valid && out_data == 16'hC444, "R10 restart at position 0", out_data, 16'hC444);
    repeat (2) @(negedge clk);

    // dropped samples flow while the output is stalled
    pulse_clear();
    scan_len = 5'd1; skip_scans = 6'd2; hi_res = 0; rdy_mode = 2;
    send(16'hABC0);
    check(out_valid && out_data == 16'h02BC, "R3 12-bit conversion", out_data, 16'h02BC);
    @(negedge clk); in_valid = 1; in_data = 16'h5555; #1;
    check(in_ready, "R9 drop accepted under stall", {15'h0, in_ready}, 16'h0001);
    @(negedge clk); in_valid = 0;
    send(16'h6666);
    check(out_valid && out_data == 16'h02BC, "R8 output held", out_data, 16'h02BC);
    @(negedge clk); in_valid = 1; in_data = 16'h7770; #1;
    check(!in_ready, "R8 kept sample waits", {15'h0, in_ready}, 16'h0000);
    repeat (3) @(negedge clk);
    #1;
    check(!in_ready && out_data == 16'h02BC, "R8 stall persists", out_data, 16'h02BC);
    rdy_mode = 0;
    send(16'h7770);
    check(out_valid && out_data == 16'h0F77, "R8 position kept after stall", out_data, 16'h0F77);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule